// File: doc/BRIEF.md
# Two-Word Coprocessor Transfer Sequencer

This block sits between a 32-bit memory data path and a bank of sixteen 64-bit coprocessor registers. It serves coprocessor load and store instructions one bus beat at a time. For each phase the host presents, the block answers either "increment the address and send another beat" or "done". A long access moves both 32-bit halves of a register over two beats. A short access moves one word.

The host supplies the instruction word, a load/store direction, a value kind (float or integer) and the system endianness. Endianness sets which half travels first in a long access. For short accesses the value kind picks the half: float values live in the upper half. Integer values live in the lower half and are sign-extended on load. Register writes are strobed per half, so a write to one half leaves the other half intact.

Top module: `cxs_xfer_seq`

## Requirements
- R1: Instruction bit 22 set marks a long access of two beats. Clear marks a single-beat access, which is always answered with done (`resp_inc_o`=0).
- R2: A non-data phase (`phase_valid_i`=1, `phase_data_i`=0) is answered with done and clears the beat count, so the next long beat is treated as a first beat.
- R3: On the first beat of a long access, big-endian (`big_endian_i`=1) uses the upper half (bits 63..32) and little-endian uses the lower half (bits 31..0). The second beat uses the other half. This applies to both loads and stores.
- R4: The first long beat is answered with increment (`resp_inc_o`=1) and the second with done. After the second beat the count returns to zero, so back-to-back long accesses each start at the first beat.
- R5: A single-beat float load (`kind_int_i`=0) writes only the upper half. The lower half keeps its value.
- R6: A single-beat integer load (`kind_int_i`=1) writes the word into the lower half and 32 copies of its bit 31 into the upper half.
- R7: A single-beat float store outputs the upper half. A single-beat integer store outputs the lower half.
- R8: Instruction bits 15..12 select one of 16 registers. A transfer touches no other register.
- R9: After reset every register holds zero, and `resp_valid_o` and `st_word_o` are zero. A cycle with `phase_valid_i`=0 produces no response.
- R10: The response and the store word are registered. They appear in the cycle after the phase. A load's data is visible to a store issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_valid_i | input | 1 | A phase is presented this cycle |
| phase_data_i | input | 1 | 1: data beat, 0: non-data phase |
| instr_i | input | 32 | Instruction word (bit 22 long, bits 15..12 register) |
| store_i | input | 1 | 1: store (register to bus), 0: load |
| kind_int_i | input | 1 | 1: integer value, 0: float value |
| big_endian_i | input | 1 | 1: big-endian half order |
| ld_word_i | input | 32 | Bus word for a load beat |
| resp_valid_o | output | 1 | Response present, one cycle after the phase |
| resp_inc_o | output | 1 | 1: increment and continue, 0: done |
| st_word_o | output | 32 | Bus word produced by the last store beat |

## Verification
Every phase yields exactly one response, one cycle after the clock edge that accepted it. A store beat's word arrives in that same cycle. The bench drives each phase on a falling edge and queues the expected response and word. On the next falling edge a monitor compares the oldest queued item with the registered outputs, and it flags any response that arrives with nothing queued. Register contents written by loads are checked by issuing stores immediately afterwards, which also covers the next-cycle visibility of load data.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
  typedef enum logic {KIND_FLT = 1'b0, KIND_INT = 1'b1} kind_e;
  typedef struct packed {
    logic vld;
    logic inc;
  } resp_t;
endpackage

// File: rtl/cxs_beat_seq.sv
module cxs_beat_seq
  import cxs_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int LONG_BIT = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_valid_i,
  input  logic               phase_data_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               big_endian_i,
  output logic               beat_o,
  output logic               long_o,
  output half_e              half_o,
  output resp_t              resp_o
);
  logic second_q;

  assign beat_o = phase_valid_i & phase_data_i;
  assign long_o = instr_i[LONG_BIT];
  // first beat: BE->upper, LE->lower; second beat swaps
  assign half_o = half_e'(second_q ^ big_endian_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      resp_o   <= '0;
    end else begin
      resp_o.vld <= phase_valid_i;
      resp_o.inc <= beat_o & long_o & ~second_q;
      if (phase_valid_i) begin
        if (!phase_data_i)  second_q <= 1'b0;
        else if (long_o)    second_q <= ~second_q;
        else                second_q <= 1'b0;
      end
    end
  end

  AST_NONDATA_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_valid_i && !phase_data_i) |=> (resp_o.vld && !resp_o.inc)); // R2
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !long_o) |=> (resp_o.vld && !resp_o.inc)); // R1
  AST_INC_NOT_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o.vld && resp_o.inc) |=> !(resp_o.vld && resp_o.inc)); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_valid_i |=> !resp_o.vld); // R9
endmodule

// File: rtl/cxs_lane_steer.sv
module cxs_lane_steer
  import cxs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                beat_i,
  input  logic                store_i,
  input  logic                long_i,
  input  kind_e               kind_i,
  input  half_e               half_i,
  input  logic [WORD_W-1:0]   ld_word_i,
  input  logic [2*WORD_W-1:0] rf_rdata_i,
  output logic [1:0]          we_o,
  output logic [2*WORD_W-1:0] wr_data_o,
  output logic [WORD_W-1:0]   st_word_o
);
  half_e st_half;

  always_comb begin
    we_o      = 2'b00;
    wr_data_o = {ld_word_i, ld_word_i};
    if (beat_i && !store_i) begin
      if (long_i) begin
        we_o[half_i] = 1'b1;
      end else if (kind_i == KIND_FLT) begin
        we_o[HALF_HI] = 1'b1;
      end else begin
        we_o      = 2'b11;
        wr_data_o = {{WORD_W{ld_word_i[WORD_W-1]}}, ld_word_i};
      end
    end
  end

  always_comb begin
    if (long_i)                 st_half = half_i;
    else if (kind_i == KIND_INT) st_half = HALF_LO;
    else                        st_half = HALF_HI;
    st_word_o = (st_half == HALF_HI) ? rf_rdata_i[2*WORD_W-1:WORD_W]
                                     : rf_rdata_i[WORD_W-1:0];
  end
endmodule

// File: rtl/cxs_half_rf.sv
module cxs_half_rf #(
  parameter int WORD_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [1:0]          we_i,
  input  logic [2*WORD_W-1:0] wr_data_i,
  output logic [2*WORD_W-1:0] rd_data_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [WORD_W-1:0] mem_q [NREGS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NREGS; r++) mem_q[r] <= '0;
      end else if (we_i[h]) begin
        mem_q[idx_i] <= wr_data_i[h*WORD_W +: WORD_W];
      end
    end

    assign rd_data_o[h*WORD_W +: WORD_W] = mem_q[idx_i];
  end
endmodule

// File: rtl/cxs_xfer_seq.sv
module cxs_xfer_seq
  import cxs_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NREGS    = 16,
  parameter int INSTR_W  = 32,
  parameter int LONG_BIT = 22,
  parameter int IDX_LSB  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_valid_i,
  input  logic               phase_data_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               store_i,
  input  logic               kind_int_i,
  input  logic               big_endian_i,
  input  logic [WORD_W-1:0]  ld_word_i,
  output logic               resp_valid_o,
  output logic               resp_inc_o,
  output logic [WORD_W-1:0]  st_word_o
);
  localparam int IDX_W = $clog2(NREGS);

  logic                beat, long_acc;
  half_e               half;
  resp_t               resp;
  logic [IDX_W-1:0]    idx;
  logic [1:0]          we;
  logic [2*WORD_W-1:0] wr_data, rd_data;
  logic [WORD_W-1:0]   st_word_d, st_word_q;
  kind_e               kind;

  assign idx  = instr_i[IDX_LSB +: IDX_W];
  assign kind = kind_e'(kind_int_i);

  cxs_beat_seq #(.INSTR_W(INSTR_W), .LONG_BIT(LONG_BIT)) u_seq (
    .clk_i, .rst_ni, .phase_valid_i, .phase_data_i, .instr_i, .big_endian_i,
    .beat_o(beat), .long_o(long_acc), .half_o(half), .resp_o(resp)
  );

  cxs_lane_steer #(.WORD_W(WORD_W)) u_steer (
    .beat_i(beat), .store_i, .long_i(long_acc), .kind_i(kind), .half_i(half),
    .ld_word_i, .rf_rdata_i(rd_data), .we_o(we), .wr_data_o(wr_data),
    .st_word_o(st_word_d)
  );

  cxs_half_rf #(.WORD_W(WORD_W), .NREGS(NREGS)) u_rf (
    .clk_i, .rst_ni, .idx_i(idx), .we_i(we), .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                st_word_q <= '0;
    else if (beat && store_i)   st_word_q <= st_word_d;
  end

  assign resp_valid_o = resp.vld;
  assign resp_inc_o   = resp.inc;
  assign st_word_o    = st_word_q;

  AST_LONG_ONE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !store_i && long_acc) |-> ($countones(we) == 1)); // R3
  AST_FLT_UPPER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !store_i && !long_acc && !kind_int_i) |-> (we == 2'b10)); // R5
  AST_INT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !store_i && !long_acc && kind_int_i) |-> (we == 2'b11)); // R6
  AST_STORE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat || store_i) |-> (we == 2'b00)); // R8
endmodule

// File: tb/cxs_xfer_seq_test.sv
module cxs_xfer_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        phase_valid = 0, phase_data = 0, store = 0, kind_int = 0, be = 0;
  logic [31:0] instr = '0, ld_word = '0;
  logic        resp_valid, resp_inc;
  logic [31:0] st_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  cxs_xfer_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_valid_i(phase_valid), .phase_data_i(phase_data),
    .instr_i(instr), .store_i(store), .kind_int_i(kind_int), .big_endian_i(be),
    .ld_word_i(ld_word), .resp_valid_o(resp_valid), .resp_inc_o(resp_inc),
    .st_word_o(st_word)
  );

  typedef struct {
    bit          inc;
    bit          chk;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0, bad = 0;
  logic [63:0] mdl [16];
  bit          sec = 0;

  task automatic fail(input string msg);
    bad++;
    $display("FAIL %s", msg);
  endtask

  // one phase; the expectation is queued for the monitor
  task automatic beat(input bit st, input bit ki, input bit lng, input bit bigend,
                      input int idx, input logic [31:0] w, input string tag);
    exp_t e;
    bit hi;
    @(negedge clk);
    phase_valid = 1; phase_data = 1; store = st; kind_int = ki; be = bigend;
    ld_word = w;
    instr = $urandom;
    instr[22] = lng;
    instr[15:12] = idx[3:0];
    hi = lng ? (sec ^ bigend) : !ki;
    e.inc = lng && !sec;
    e.chk = st;
    e.tag = tag;
    e.data = hi ? mdl[idx][63:32] : mdl[idx][31:0];
    if (!st) begin
      if (lng) begin
        if (hi) mdl[idx][63:32] = w; else mdl[idx][31:0] = w;
      end else if (!ki) begin
        mdl[idx][63:32] = w;
      end else begin
        mdl[idx] = {{32{w[31]}}, w};
      end
    end
    sec = lng ? !sec : 1'b0;
    q.push_back(e);
  endtask

  task automatic nondata(input string tag);
    exp_t e;
    @(negedge clk);
    phase_valid = 1; phase_data = 0; instr = $urandom;
    e.inc = 0; e.chk = 0; e.data = '0; e.tag = tag;
    sec = 0;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    phase_valid = 0; phase_data = 0;
  endtask

  task automatic ld_long(input int idx, input bit bigend, input logic [31:0] w0,
                         input logic [31:0] w1, input string tag);
    beat(0, 1, 1, bigend, idx, w0, tag);
    beat(0, 1, 1, bigend, idx, w1, tag);
  endtask

  task automatic st_long(input int idx, input bit bigend, input string tag);
    beat(1, 0, 1, bigend, idx, 32'h0, tag);
    beat(1, 0, 1, bigend, idx, 32'h0, tag);
  endtask

  // monitor: pops and compares one item per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q.size() == 0) begin
        total++;
        fail("R9 response with nothing pending: got valid=1 exp valid=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (resp_inc !== e.inc)
          fail($sformatf("%s resp_inc got %0b exp %0b", e.tag, resp_inc, e.inc));
        if (e.chk) begin
          total++;
          if (st_word !== e.data)
            fail($sformatf("%s st_word got %h exp %h", e.tag, st_word, e.data));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    fail("watchdog expired: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (resp_valid !== 1'b0 || st_word !== 32'h0)
      fail($sformatf("R9 reset state got valid=%0b word=%h exp 0/0", resp_valid, st_word));

    st_long(3, 0, "R9 reset regs zero");
    ld_long(3, 0, 32'hAAAA_0001, 32'hBBBB_0002, "R3 LE load");
    st_long(3, 0, "R3 R4 R10 LE store order");
    st_long(3, 1, "R3 BE store order");
    idle();
    ld_long(5, 1, 32'hCCCC_0003, 32'hDDDD_0004, "R3 BE load");
    beat(1, 1, 0, 0, 5, 0, "R7 R1 int single store lower");
    beat(1, 0, 0, 1, 5, 0, "R7 R1 float single store upper");
    beat(0, 0, 0, 0, 5, 32'hEEEE_0005, "R5 float single load");
    st_long(5, 0, "R5 lower half kept");
    beat(0, 1, 0, 0, 7, 32'h8000_0001, "R6 int load negative");
    st_long(7, 0, "R6 sign extension negative");
    beat(0, 1, 0, 1, 7, 32'h0000_1234, "R6 int load positive");
    st_long(7, 1, "R6 sign extension positive");
    beat(0, 1, 1, 0, 9, 32'h1111_1111, "R2 partial long beat");
    nondata("R2 non-data done");
    ld_long(9, 0, 32'h2222_2222, 32'h3333_3333, "R2 restart at first beat");
    st_long(9, 0, "R2 contents after restart");
    ld_long(15, 0, 32'hF0F0_0F0F, 32'h0F0F_F0F0, "R8 load r15");
    ld_long(0, 1, 32'h1357_9BDF, 32'h2468_ACE0, "R8 load r0");
    st_long(14, 0, "R8 r14 untouched");
    st_long(15, 1, "R8 r15 readback");
    st_long(0, 0, "R8 r0 readback");
    idle();
    idle();
    beat(1, 1, 0, 0, 3, 0, "R7 R4 single after idle");
    nondata("R2 plain non-data");
    idle();
    repeat (4) idle();
    total++;
    if (q.size() != 0)
      fail($sformatf("R10 pending responses got %0d exp 0", q.size()));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule